// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is a byte-oriented asynchronous serial port attached to a simple 32-bit register bus. Software queues outgoing bytes by writing a data register, and collects incoming bytes by reading a second data register. Each of those words also carries a status flag in bit 31. Two byte queues, each eight deep by default, separate the bus from a transmit engine and a receive engine. Every frame is one start bit, eight data bits sent least significant bit first, no parity, and one or two stop bits. Each bit lasts divisor+1 clock cycles.

The interrupt does not fire once per character. Each direction has a programmable occupancy level. The transmit side is pending while its queue holds fewer bytes than its level. The receive side is pending while its queue holds more bytes than its level. One level-sensitive interrupt output is the OR of the enabled pending conditions.

The bus has no stall and no handshake. Every access completes in the cycle it is presented, and read data is valid in that same cycle. Flow control between software and the port uses only the status flags and the watermarks: a full transmit queue drops further writes, and an empty receive queue returns the empty flag.

Top module: `uart_wm`

## Requirements
- R1: After reset, every control register reads 0 and both queues are empty. The interrupt is low, the transmit line is high, and a receive-data read returns bit 31 set.
- R2: The register offsets are 0x00 tx data, 0x04 rx data, 0x08 tx control, 0x0C rx control, 0x10 enable, 0x14 pending and 0x18 divisor.
  - Tx control fields: bit 0 enables transmission, bit 1 selects two stop bits, and bits [18:16] hold the level.
  - Rx control fields: bit 0 enables reception and bits [18:16] hold the level.
  - Enable and pending share one layout: bit 0 is transmit and bit 1 is receive.
  - The divisor occupies bits [15:0].
  - Unused bits read 0, and writes to the pending register have no effect.
- R3: A tx-data write pushes bits [7:0] into the transmit queue. When the queue already holds 8 bytes, the write is dropped. A tx-data read returns bit 31 set exactly while the queue is full.
- R4: An rx-data read returns the oldest byte in bits [7:0] with bit 31 clear, and removes that byte. When the queue is empty, the read returns bit 31 set and removes nothing.
- R5: While transmission is enabled, queued bytes leave in order. Each frame is a low start bit, then 8 data bits least significant bit first, then one or two high stop bits. Every bit lasts divisor+1 cycles. Consecutive queued bytes follow each other with no idle gap.
- R6: The transmit pending bit is 1 exactly while the transmit queue occupancy is below the tx level.
- R7: The receive pending bit is 1 exactly while the receive queue occupancy is above the rx level.
- R8: The interrupt output is high exactly when some pending bit and its matching enable bit are both 1.
- R9: The receiver passes the line through two flops and looks for a falling edge. It confirms the start bit at mid-bit and samples each data bit at its midpoint. A frame whose stop bit samples low is discarded. Reception requires a divisor of at least 2.
- R10: While receive enable is 0, no new frame is accepted.
- R11: A byte that completes while the receive queue holds 8 bytes is dropped, and the bytes already queued are kept.
- R12: The transmit queue can go empty while the last frame is still leaving. The transmit pending bit can therefore be 1 while the line is still mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; an rx-data read pops on the clock edge |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| tx_line | output | 1 | Serial output, idle high |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: 8-deep queues, a 16-bit divisor and 3-bit levels. With those parameters, levels 0 to 7 reach both watermark boundaries, including full-queue states in which no level can flag pending. At run time the bench programs short divisors of 3 and 9. Short divisors keep a frame to 40-110 cycles, so draining a full queue, overflowing the receive queue with nine frames, and catching the line mid-frame after the queue has emptied all fit in a short run.

// File: rtl/uart_wm_pkg.sv
package uart_wm_pkg;
  localparam int REG_AW     = 5;
  localparam int FRAME_BITS = 8;
  localparam int FLAG_BIT   = 31;
  localparam int LVL_LSB    = 16;

  localparam logic [REG_AW-1:0] OFS_TXDATA = 5'h00;
  localparam logic [REG_AW-1:0] OFS_RXDATA = 5'h04;
  localparam logic [REG_AW-1:0] OFS_TXCTRL = 5'h08;
  localparam logic [REG_AW-1:0] OFS_RXCTRL = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_IE     = 5'h10;
  localparam logic [REG_AW-1:0] OFS_IP     = 5'h14;
  localparam logic [REG_AW-1:0] OFS_DIV    = 5'h18;

  localparam int WM_TX = 0;
  localparam int WM_RX = 1;

  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/uart_wm_fifo.sv
module uart_wm_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) (push && !pop && full) |=> full); // R11
  AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n) (pop && !push && empty) |=> empty); // R4
endmodule

// File: rtl/uart_wm_tx.sv
module uart_wm_tx
  import uart_wm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             two_stop,
  input  logic [DIV_W-1:0] div,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_data,
  output logic             fifo_pop,
  output logic             txd
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  tx_state_e        st;
  logic [DIV_W-1:0] cnt;
  logic [BW-1:0]    bitn;
  logic [7:0]       sh;
  logic             second;
  logic             tick, stop_done, launch;

  assign tick      = (cnt >= div);
  assign stop_done = (st == TX_STOP) && tick && (!two_stop || second);
  assign launch    = en && !fifo_empty && ((st == TX_IDLE) || stop_done);
  assign fifo_pop  = launch;

  always_comb begin
    case (st)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = sh[0];
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= TX_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      second <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (launch) begin
            st  <= TX_START;
            cnt <= '0;
            sh  <= fifo_data;
          end
        end
        TX_START: begin
          if (tick) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= TX_DATA;
          end else cnt <= cnt + DIV_W'(1);
        end
        TX_DATA: begin
          if (tick) begin
            cnt <= '0;
            sh  <= {1'b0, sh[7:1]};
            if (bitn == LAST_BIT) begin
              st     <= TX_STOP;
              second <= 1'b0;
            end else bitn <= bitn + BW'(1);
          end else cnt <= cnt + DIV_W'(1);
        end
        default: begin
          if (tick) begin
            cnt <= '0;
            if (two_stop && !second) second <= 1'b1;
            else if (launch) begin
              st <= TX_START;
              sh <= fifo_data;
            end else st <= TX_IDLE;
          end else cnt <= cnt + DIV_W'(1);
        end
      endcase
    end
  end

  AST_TX_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (st != TX_IDLE && cnt < div) |=> $stable(txd)); // R5
  AST_TX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (st == TX_IDLE && !en) |=> txd); // R5
endmodule

// File: rtl/uart_wm_rx.sv
module uart_wm_rx
  import uart_wm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd,
  output logic             push,
  output logic [7:0]       byte_out
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  rx_state_e        st;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;
  logic [BW-1:0]    bitn;
  logic [7:0]       sh;
  logic             s1, s2, sd;

  assign half = div >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      sd <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      sd <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      sh       <= '0;
      push     <= 1'b0;
      byte_out <= '0;
    end else begin
      push <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (en && sd && !s2) begin
            st  <= RX_START;
            cnt <= DIV_W'(1);
          end
        end
        RX_START: begin
          if (cnt >= half) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= s2 ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + DIV_W'(1);
        end
        RX_DATA: begin
          if (cnt >= div) begin
            cnt <= '0;
            sh  <= {s2, sh[7:1]};
            if (bitn == LAST_BIT) st <= RX_STOP;
            else bitn <= bitn + BW'(1);
          end else cnt <= cnt + DIV_W'(1);
        end
        default: begin
          if (cnt >= div) begin
            st       <= RX_IDLE;
            push     <= s2;
            byte_out <= sh;
          end else cnt <= cnt + DIV_W'(1);
        end
      endcase
    end
  end

  AST_RX_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (st == RX_IDLE && !en) |=> st == RX_IDLE); // R10
  AST_RX_BAD_STOP_DROP: assert property (@(posedge clk) disable iff (!rst_n) (st == RX_STOP && cnt >= div && !s2) |=> !push); // R9
endmodule

// File: rtl/uart_wm_regs.sv
module uart_wm_regs
  import uart_wm_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int LVL_W = 3,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              tx_full,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              rx_empty,
  input  logic [7:0]        rx_head,
  input  logic [CNT_W-1:0]  rx_count,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  output logic              rx_pop,
  output logic              tx_en,
  output logic              tx_two_stop,
  output logic              rx_en,
  output logic [DIV_W-1:0]  div,
  output logic              irq
);
  localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic [1:0]       ie_q, ip;

  assign tx_push = bus_wr && (bus_addr == OFS_TXDATA);
  assign tx_byte = bus_wdata[7:0];
  assign rx_pop  = bus_rd && (bus_addr == OFS_RXDATA);

  assign ip[WM_TX] = CMP_W'(tx_count) < CMP_W'(tx_lvl);
  assign ip[WM_RX] = CMP_W'(rx_count) > CMP_W'(rx_lvl);
  assign irq       = |(ie_q & ip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en       <= 1'b0;
      tx_two_stop <= 1'b0;
      tx_lvl      <= '0;
      rx_en       <= 1'b0;
      rx_lvl      <= '0;
      ie_q        <= '0;
      div         <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_TXCTRL: begin
          tx_en       <= bus_wdata[0];
          tx_two_stop <= bus_wdata[1];
          tx_lvl      <= bus_wdata[LVL_LSB +: LVL_W];
        end
        OFS_RXCTRL: begin
          rx_en  <= bus_wdata[0];
          rx_lvl <= bus_wdata[LVL_LSB +: LVL_W];
        end
        OFS_IE:  ie_q <= bus_wdata[1:0];
        OFS_DIV: div  <= bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_TXDATA: bus_rdata[FLAG_BIT] = tx_full;
      OFS_RXDATA: begin
        bus_rdata[FLAG_BIT] = rx_empty;
        bus_rdata[7:0]      = rx_head;
      end
      OFS_TXCTRL: begin
        bus_rdata[0]                  = tx_en;
        bus_rdata[1]                  = tx_two_stop;
        bus_rdata[LVL_LSB +: LVL_W]   = tx_lvl;
      end
      OFS_RXCTRL: begin
        bus_rdata[0]                  = rx_en;
        bus_rdata[LVL_LSB +: LVL_W]   = rx_lvl;
      end
      OFS_IE:  bus_rdata[1:0]       = ie_q;
      OFS_IP:  bus_rdata[1:0]       = ip;
      OFS_DIV: bus_rdata[DIV_W-1:0] = div;
      default: bus_rdata = '0;
    endcase
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) (ie_q == 2'b00) |-> !irq); // R8
  AST_TX_WM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (tx_count == '0 && tx_lvl != '0 && ie_q[WM_TX]) |-> irq); // R6
  AST_RX_WM_FULL: assert property (@(posedge clk) disable iff (!rst_n) (rx_count == CNT_W'(8) && ie_q[WM_RX] && rx_lvl != '1) |-> irq); // R7
endmodule

// File: rtl/uart_wm.sv
module uart_wm
  import uart_wm_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 16,
  parameter int LVL_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              rx_line,
  output logic              tx_line,
  output logic              irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic [7:0]       tx_byte, tx_head;
  logic [CNT_W-1:0] tx_count;
  logic             rx_push, rx_pop, rx_full, rx_empty;
  logic [7:0]       rx_byte, rx_head;
  logic [CNT_W-1:0] rx_count;
  logic             tx_en, tx_two_stop, rx_en;
  logic [DIV_W-1:0] div;

  uart_wm_regs #(.DIV_W(DIV_W), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tx_full(tx_full), .tx_count(tx_count),
    .rx_empty(rx_empty), .rx_head(rx_head), .rx_count(rx_count),
    .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop),
    .tx_en(tx_en), .tx_two_stop(tx_two_stop), .rx_en(rx_en),
    .div(div), .irq(irq)
  );

  uart_wm_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .CW(CNT_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_byte),
    .pop(tx_pop), .dout(tx_head), .count(tx_count),
    .full(tx_full), .empty(tx_empty)
  );

  uart_wm_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .CW(CNT_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_head), .count(rx_count),
    .full(rx_full), .empty(rx_empty)
  );

  uart_wm_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .two_stop(tx_two_stop),
    .div(div), .fifo_empty(tx_empty), .fifo_data(tx_head),
    .fifo_pop(tx_pop), .txd(tx_line)
  );

  uart_wm_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .div(div),
    .rxd(rx_line), .push(rx_push), .byte_out(rx_byte)
  );

  AST_RX_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (rx_full && rx_push && !rx_pop) |=> rx_full); // R11
  AST_TX_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |=> !(tx_count == CNT_W'(FIFO_DEPTH) && !$past(tx_push))); // R3
endmodule

// File: tb/sim_uart_wm.sv
`timescale 1ns/1ps
module sim_uart_wm;
  localparam logic [4:0] A_TXD = 5'h00, A_RXD = 5'h04, A_TXC = 5'h08, A_RXC = 5'h0C,
                         A_IE = 5'h10, A_IP = 5'h14, A_DIV = 5'h18;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        rx_line = 1'b1, tx_line, irq;

  uart_wm u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_line(rx_line), .tx_line(tx_line), .irq(irq)
  );

  int tests = 0, fails = 0, cyc = 0;
  int bdiv = 3;
  bit bstop2 = 1'b0;
  bit quiet = 1'b0;
  logic [7:0] mon_q[$];
  int mon_t[$];
  logic [1:0] m_ie = 2'b00;
  int m_txlvl = 0, m_rxlvl = 0, m_txn = 0;
  bit m_rxen = 1'b0;
  logic [7:0] m_rxq[$];

  always @(posedge clk) cyc++;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // R8 / R6 / R7: behavioural model of the interrupt compared on every clock when no frame is in flight
  always @(negedge clk) begin
    #1;
    if (rst_n && quiet) begin
      logic e;
      e = (m_ie[0] && (m_txn < m_txlvl)) || (m_ie[1] && (m_rxq.size() > m_rxlvl));
      chk("R8 irq vs model", {31'b0, irq}, {31'b0, e});
    end
  end

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #0.5;
    case (a)
      A_TXD: if (m_txn < 8) m_txn++;
      A_TXC: m_txlvl = int'(d[18:16]);
      A_RXC: begin m_rxlvl = int'(d[18:16]); m_rxen = d[0]; end
      A_IE:  m_ie = d[1:0];
      default: ;
    endcase
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk);
    #0.5;
    if (a == A_RXD && m_rxq.size() > 0) void'(m_rxq.pop_front());
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    chk(tag, d, exp);
  endtask

  task automatic rx_chk(input string tag);
    logic [31:0] d, e;
    e = (m_rxq.size() == 0) ? 32'h8000_0000 : {24'b0, m_rxq[0]};
    bus_read(A_RXD, d);
    if (e[31]) chk(tag, {d[31], 31'b0}, e);
    else chk(tag, d, e);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit stop_ok);
    int p;
    p = bdiv + 1;
    quiet = 1'b0;
    @(negedge clk);
    rx_line = 1'b0;
    repeat (p) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rx_line = b[k];
      repeat (p) @(negedge clk);
    end
    rx_line = stop_ok;
    repeat (p) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * p) @(negedge clk);
    if (m_rxen && stop_ok && m_rxq.size() < 8) m_rxq.push_back(b);
    quiet = 1'b1;
  endtask

  task automatic wait_frames(input int n);
    int g;
    g = 0;
    while (mon_q.size() < n && g < 4000) begin
      @(negedge clk);
      g++;
    end
  endtask

  // serial monitor on the transmit line, sampling at bit midpoints
  initial begin
    logic prev;
    logic [7:0] b;
    int st, p;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst_n) begin prev = 1'b1; continue; end
      if (prev && !tx_line) begin
        st = cyc;
        p = bdiv + 1;
        repeat (p / 2) @(negedge clk);
        chk("R5 start bit low at mid", {31'b0, tx_line}, 32'd0);
        for (int k = 0; k < 8; k++) begin
          repeat (p) @(negedge clk);
          b[k] = tx_line;
        end
        repeat (p) @(negedge clk);
        chk("R5 first stop bit high", {31'b0, tx_line}, 32'd1);
        if (bstop2) begin
          repeat (p) @(negedge clk);
          chk("R5 second stop bit high", {31'b0, tx_line}, 32'd1);
        end
        mon_q.push_back(b);
        mon_t.push_back(st);
      end
      prev = tx_line;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq low after reset", {31'b0, irq}, 32'd0);
    chk("R1 tx line idle high", {31'b0, tx_line}, 32'd1);
    rd_chk("R1 txctrl reset", A_TXC, 32'h0);
    rd_chk("R1 rxctrl reset", A_RXC, 32'h0);
    rd_chk("R1 ie reset", A_IE, 32'h0);
    rd_chk("R1 ip reset", A_IP, 32'h0);
    rd_chk("R1 div reset", A_DIV, 32'h0);
    rd_chk("R1 txdata not full", A_TXD, 32'h0);
    rx_chk("R1 rxdata empty flag");
    quiet = 1'b1;

    // R2 register map and field positions
    bus_write(A_DIV, 32'hFFFF_1234);
    rd_chk("R2 div field", A_DIV, 32'h0000_1234);
    bus_write(A_TXC, 32'hFFFF_FFFE);
    rd_chk("R2 txctrl fields", A_TXC, 32'h0007_0002);
    bus_write(A_RXC, 32'hFFFF_FFFE);
    rd_chk("R2 rxctrl fields", A_RXC, 32'h0007_0000);
    bus_write(A_IE, 32'hFFFF_FFFF);
    rd_chk("R2 ie fields", A_IE, 32'h3);
    bus_write(A_IE, 32'h0);
    bus_write(A_RXC, 32'h0);
    bus_write(A_DIV, 32'd3);
    bdiv = 3;

    // R6 transmit watermark, R8 gating, R2 pending register is not writable
    bus_write(A_IE, 32'h1);
    bus_write(A_TXC, 32'h0001_0000);
    rd_chk("R6 tx pending with empty queue at level 1", A_IP, 32'h1);
    bus_write(A_IP, 32'h0);
    rd_chk("R2 ip write ignored", A_IP, 32'h1);
    chk("R8 irq with enabled pending", {31'b0, irq}, 32'd1);
    bus_write(A_TXC, 32'h0007_0000);
    for (int i = 0; i < 6; i++) bus_write(A_TXD, 32'hA0 + i);
    rd_chk("R6 six below level seven", A_IP, 32'h1);
    bus_write(A_TXD, 32'hA6);
    rd_chk("R6 seven not below seven", A_IP, 32'h0);
    rd_chk("R3 not full at seven", A_TXD, 32'h0);
    bus_write(A_TXD, 32'hA7);
    rd_chk("R3 full flag at eight", A_TXD, 32'h8000_0000);
    bus_write(A_TXD, 32'h55);

    // R5 transmit order and timing, R3 dropped write
    quiet = 1'b0;
    bus_write(A_TXC, 32'h0001_0001);
    wait_frames(8);
    repeat (120) @(negedge clk);
    chk("R3 overflow write dropped", mon_q.size(), 32'd8);
    for (int i = 0; i < 8 && i < mon_q.size(); i++)
      chk("R5 byte order", {24'b0, mon_q[i]}, 32'hA0 + i);
    for (int i = 0; i + 1 < mon_t.size(); i++)
      chk("R5 back-to-back spacing one stop", mon_t[i+1] - mon_t[i], 32'd40);
    mon_q.delete(); mon_t.delete();
    m_txn = 0;
    quiet = 1'b1;

    // R5 two stop bits
    bstop2 = 1'b1;
    quiet = 1'b0;
    bus_write(A_TXC, 32'h0001_0003);
    bus_write(A_TXD, 32'h3C);
    bus_write(A_TXD, 32'hC3);
    wait_frames(2);
    repeat (60) @(negedge clk);
    chk("R5 frames sent with two stops", mon_q.size(), 32'd2);
    if (mon_q.size() == 2) begin
      chk("R5 first byte two stops", {24'b0, mon_q[0]}, 32'h3C);
      chk("R5 second byte two stops", {24'b0, mon_q[1]}, 32'hC3);
      chk("R5 spacing two stops", mon_t[1] - mon_t[0], 32'd44);
    end
    mon_q.delete(); mon_t.delete();
    bstop2 = 1'b0;
    bus_write(A_TXC, 32'h0001_0001);
    m_txn = 0;
    quiet = 1'b1;

    // R12 queue empty while frame still leaving
    bus_write(A_DIV, 32'd9);
    bdiv = 9;
    quiet = 1'b0;
    bus_write(A_TXD, 32'h00);
    repeat (3) @(negedge clk);
    bus_read(A_IP, d);
    chk("R12 tx pending while frame in flight", {31'b0, d[0]}, 32'd1);
    chk("R12 line still inside frame", {31'b0, tx_line}, 32'd0);
    wait_frames(1);
    repeat (30) @(negedge clk);
    chk("R12 frame completed", mon_q.size(), 32'd1);
    if (mon_q.size() == 1) chk("R12 frame byte", {24'b0, mon_q[0]}, 32'h00);
    mon_q.delete(); mon_t.delete();
    m_txn = 0;
    quiet = 1'b1;
    bus_write(A_DIV, 32'd3);
    bdiv = 3;

    // R7 / R4 / R9 receive path
    bus_write(A_IE, 32'h2);
    bus_write(A_RXC, 32'h0000_0001);
    send_frame(8'h5A, 1'b1);
    rd_chk("R7 rx pending at level 0 with one byte", A_IP, 32'h3);
    chk("R8 irq from rx watermark", {31'b0, irq}, 32'd1);
    rx_chk("R9 received byte midpoint sampled");
    rx_chk("R4 empty read flag");
    rd_chk("R4 empty read popped nothing", A_IP, 32'h1);
    bus_write(A_RXC, 32'h0002_0001);
    send_frame(8'h01, 1'b1);
    send_frame(8'h02, 1'b1);
    rd_chk("R7 two not above level two", A_IP, 32'h1);
    send_frame(8'h03, 1'b1);
    rd_chk("R7 three above level two", A_IP, 32'h3);
    rx_chk("R4 oldest first a");
    rx_chk("R4 oldest first b");
    rx_chk("R4 oldest first c");

    // R9 bad stop bit discarded
    bus_write(A_RXC, 32'h0000_0001);
    send_frame(8'h77, 1'b0);
    send_frame(8'h11, 1'b1);
    rx_chk("R9 good frame after bad stop");
    rx_chk("R9 bad stop frame discarded");

    // R10 receive disabled
    bus_write(A_RXC, 32'h0);
    send_frame(8'h22, 1'b1);
    rx_chk("R10 frame ignored while disabled");
    bus_write(A_RXC, 32'h0000_0001);

    // R11 receive overflow
    for (int i = 0; i < 9; i++) send_frame(8'h80 + 8'(i), 1'b1);
    chk("R11 model holds eight", m_rxq.size(), 32'd8);
    bus_write(A_IE, 32'h0);
    chk("R8 irq low with enables clear", {31'b0, irq}, 32'd0);
    for (int i = 0; i < 8; i++) rx_chk("R11 kept bytes in order");
    rx_chk("R11 ninth byte dropped");

    repeat (10) @(negedge clk);
    quiet = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule